// File: doc/BRIEF.md
# Pin I/O Bank with Edge and Level Interrupts

The block is one bank of general-purpose pins. Each pin can drive a stored data bit or a shared blink waveform. Each pin also has an output-enable bit. Both the data bits and the enable bits can be changed atomically through write-only set and clear aliases. Incoming pad values pass through a two-flop synchronizer. A per-pin polarity bit inverts them before software sees them and before they feed interrupt detection.

Interrupt detection is per pin and has two modes:
- **Edge mode:** active transitions latch into a cause register. Software clears that register one bit at a time by writing 1s.
- **Level mode:** the interrupt follows the polarity-adjusted input directly and is never latched.

The polarity bit sets the trigger sense for both modes. One combined interrupt line collects every enabled source.

Software reaches the bank through a plain register port: request, write enable, a 6-bit byte address, 32-bit write data, and combinational read data. The port has no wait states.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register reads 0, `pad_o`, `pad_oe_o` and `irq_o` are 0, and all pins are inputs.
- R2: The registers hold and read back what was written:
  - output data at 0x00;
  - output enable at 0x04 (1 = output);
  - blink enable at 0x08;
  - polarity at 0x0C;
  - edge mask at 0x18;
  - level mask at 0x1C;
  - blink period at 0x20 (low 16 bits).
  
  `pad_oe_o` equals the output-enable register. `pad_o` equals the data register for pins whose blink bit is 0.
- R3: A write to 0x30 sets the data bits that are written as 1. A write to 0x28 sets the output-enable bits that are written as 1. Bits written as 0 are unchanged in both cases, and both aliases read as 0.
- R4: A write to 0x34 clears the data bits that are written as 1. A write to 0x2C clears the output-enable bits that are written as 1. Bits written as 0 are unchanged in both cases, and both aliases read as 0.
- R5: Reading 0x10 returns the pad value XOR the polarity register. A pad change becomes visible after two rising clock edges. Writes to 0x10 and to unmapped offsets change no state, and unmapped offsets read as 0.
- R6: A cause bit (read at 0x14) is set one edge after the synchronized pad makes an active transition:
  - low to high when polarity is 0;
  - high to low when polarity is 1.
  
  The opposite transition does not set it. Once set, the bit stays set until software clears it.
- R7: Writing 1s to 0x14 clears those cause bits, and bits written as 0 stay set. If an active edge arrives in the same cycle as the clear for that bit, the bit stays set.
- R8: `irq_o` is high exactly when either of these holds:
  - a cause bit is set while its edge-mask bit is set;
  - a polarity-adjusted input is 1 while its level-mask bit is set.
  
  Level interrupts are not latched, and clearing the level-mask bit removes them.
- R9: For a pin whose blink bit is 1, `pad_o` follows a shared phase that toggles every P+1 clock cycles, where P is the blink period register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pad_i | input | NUM_PINS | Raw pad inputs |
| pad_o | output | NUM_PINS | Pad output values |
| pad_oe_o | output | NUM_PINS | Pad output enables (1 = drive) |
| irq_o | output | 1 | Combined interrupt |

## Verification
Edge detection is swept over every pin under both polarities, driving first the active transition and then the opposite one. This separates correct direction selection from plain change detection, and a stuck or shifted cause bit from a correct one.

Level mode is swept per pin with the pad held inactive, then active, then inactive again, plus a mask removal while the pad stays active. This tells a following interrupt from a latched one.

A clear is timed to land in the same cycle as a new edge, alongside the clear of another pending bit. This distinguishes edge-wins priority from a plain clear.

Alias writes use mixed bit patterns, so lost bits show up as well as whole-word overwrites. The blink interval is measured between two successive output transitions.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_AW = 6;
  localparam int REG_DW = 32;

  typedef enum logic [REG_AW-1:0] {
    OFS_DOUT  = 6'h00,
    OFS_CTRL  = 6'h04,
    OFS_BLINK = 6'h08,
    OFS_POL   = 6'h0C,
    OFS_DIN   = 6'h10,
    OFS_CAUSE = 6'h14,
    OFS_EMASK = 6'h18,
    OFS_LMASK = 6'h1C,
    OFS_BPER  = 6'h20,
    OFS_CSET  = 6'h28,
    OFS_CCLR  = 6'h2C,
    OFS_DSET  = 6'h30,
    OFS_DCLR  = 6'h34
  } reg_ofs_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] emask_i,
  input  logic [W-1:0] lmask_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] cause_o,
  output logic         irq_o
);
  logic [W-1:0] prev_q, cause_q, evt;

  // direction taken from raw values so a polarity change never fakes an edge
  assign evt     = (sync_i & ~prev_q & ~pol_i) | (~sync_i & prev_q & pol_i);
  assign level_o = sync_i ^ pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= sync_i;
      cause_q <= (cause_q & ~clr_i) | evt;
    end
  end

  assign cause_o = cause_q;
  assign irq_o   = |((cause_q & emask_i) | (level_o & lmask_i));

  AST_CAUSE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause_q & $past(cause_q) & ~$past(clr_i)) == ($past(cause_q) & ~$past(clr_i)))); // R6
  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt & clr_i)) |=> ((cause_q & $past(evt & clr_i)) == $past(evt & clr_i))); // R7
endmodule

// File: rtl/gpio_bank_blink.sv
module gpio_bank_blink #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] period_i,
  output logic          phase_o
);
  logic [CW-1:0] cnt_q;
  logic          phase_q, tick;

  // >= so a period lowered below the running count still ticks at once
  assign tick = (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= tick ? '0 : cnt_q + 1'b1;
      phase_q <= phase_q ^ tick;
    end
  end

  assign phase_o = phase_q;

  AST_PHASE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(phase_q)); // R9
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int BLINK_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [REG_DW-1:0]   wdata_i,
  output logic [REG_DW-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);
  localparam int NP = NUM_PINS;

  logic [NP-1:0] dout_q, ctrl_q, blink_q, pol_q, emask_q, lmask_q;
  logic [BLINK_W-1:0] bper_q;
  logic [NP-1:0] w, sync_v, level_v, cause_v, clr_v;
  logic wr, phase;

  assign wr    = req_i & we_i;
  assign w     = wdata_i[NP-1:0];
  assign clr_v = (wr && addr_i == OFS_CAUSE) ? w : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      ctrl_q  <= '0;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
      bper_q  <= '0;
    end else if (wr) begin
      unique case (addr_i)
        OFS_DOUT:  dout_q  <= w;
        OFS_DSET:  dout_q  <= dout_q | w;
        OFS_DCLR:  dout_q  <= dout_q & ~w;
        OFS_CTRL:  ctrl_q  <= w;
        OFS_CSET:  ctrl_q  <= ctrl_q | w;
        OFS_CCLR:  ctrl_q  <= ctrl_q & ~w;
        OFS_BLINK: blink_q <= w;
        OFS_POL:   pol_q   <= w;
        OFS_EMASK: emask_q <= w;
        OFS_LMASK: lmask_q <= w;
        OFS_BPER:  bper_q  <= wdata_i[BLINK_W-1:0];
        default: ;
      endcase
    end
  end

  gpio_bank_sync #(.W(NP)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (pad_i), .q_o (sync_v)
  );

  gpio_bank_irq #(.W(NP)) u_irq (
    .clk_i (clk_i), .rst_ni (rst_ni), .sync_i (sync_v), .pol_i (pol_q),
    .emask_i (emask_q), .lmask_i (lmask_q), .clr_i (clr_v),
    .level_o (level_v), .cause_o (cause_v), .irq_o (irq_o)
  );

  gpio_bank_blink #(.CW(BLINK_W)) u_blink (
    .clk_i (clk_i), .rst_ni (rst_ni), .period_i (bper_q), .phase_o (phase)
  );

  for (genvar i = 0; i < NP; i++) begin : g_pad
    assign pad_o[i] = blink_q[i] ? phase : dout_q[i];
  end
  assign pad_oe_o = ctrl_q;

  always_comb begin
    unique case (addr_i)
      OFS_DOUT:  rdata_o = REG_DW'(dout_q);
      OFS_CTRL:  rdata_o = REG_DW'(ctrl_q);
      OFS_BLINK: rdata_o = REG_DW'(blink_q);
      OFS_POL:   rdata_o = REG_DW'(pol_q);
      OFS_DIN:   rdata_o = REG_DW'(level_v);
      OFS_CAUSE: rdata_o = REG_DW'(cause_v);
      OFS_EMASK: rdata_o = REG_DW'(emask_q);
      OFS_LMASK: rdata_o = REG_DW'(lmask_q);
      OFS_BPER:  rdata_o = REG_DW'(bper_q);
      default:   rdata_o = '0;
    endcase
  end

  AST_DSET_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_DSET) |=> ((dout_q & $past(w)) == $past(w))); // R3
  AST_CCLR_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_CCLR) |=> ((ctrl_q & $past(w)) == '0)); // R4
  AST_DIN_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_DIN) |=> ($stable(dout_q) && $stable(ctrl_q) && $stable(pol_q))); // R5
endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata, pads = '0, pad_o, pad_oe;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_bank dut_i (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .pad_i (pads), .pad_o (pad_o),
    .pad_oe_o (pad_oe), .irq_o (irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, pol;
    int t0, t1, cyc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    foreach (v[k]) ;
    for (int a = 0; a < 64; a += 4) begin
      rd(6'(a), v); check($sformatf("R1 reg %0h", a), v, 0);
    end
    check("R1 pad_o", pad_o, 0);
    check("R1 pad_oe", pad_oe, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // R2 plain registers
    wr(6'h00, 32'h1234_5678); wr(6'h04, 32'h0F0F_00FF);
    wr(6'h18, 32'hDEAD_BEEF); wr(6'h1C, 32'h0);
    wr(6'h20, 32'hFFFF_0007);
    rd(6'h00, v); check("R2 dout", v, 32'h1234_5678);
    rd(6'h04, v); check("R2 ctrl", v, 32'h0F0F_00FF);
    rd(6'h18, v); check("R2 emask", v, 32'hDEAD_BEEF);
    rd(6'h20, v); check("R2 period", v, 32'h0000_0007);
    check("R2 pad_o", pad_o, 32'h1234_5678);
    check("R2 pad_oe", pad_oe, 32'h0F0F_00FF);
    wr(6'h18, 32'h0); wr(6'h20, 32'h0);

    // R3 / R4 aliases
    wr(6'h00, 32'hA5A5_0F0F); wr(6'h30, 32'h0000_F0F0);
    check("R3 data set", pad_o, 32'hA5A5_FFFF);
    wr(6'h34, 32'hA500_0000);
    check("R4 data clear", pad_o, 32'h00A5_FFFF);
    wr(6'h04, 32'h3C00_0001); wr(6'h28, 32'h0000_0110);
    check("R3 ctrl set", pad_oe, 32'h3C00_0111);
    wr(6'h2C, 32'h1400_0100);
    check("R4 ctrl clear", pad_oe, 32'h2800_0011);
    rd(6'h28, v); check("R3 alias reads 0", v, 0);
    rd(6'h34, v); check("R4 alias reads 0", v, 0);

    // R5 input read-only, unmapped ignored
    wr(6'h10, 32'hFFFF_FFFF); wr(6'h3C, 32'hFFFF_FFFF);
    check("R5 ro write pad_o", pad_o, 32'h00A5_FFFF);
    check("R5 ro write pad_oe", pad_oe, 32'h2800_0011);
    rd(6'h3C, v); check("R5 unmapped reads 0", v, 0);
    rd(6'h10, v); check("R5 din idle", v, 0);

    // R6/R7/R8 edge sweep per pin and polarity
    wr(6'h18, 32'hFFFF_FFFF);
    for (int p = 0; p < 2; p++) begin
      pol = p ? 32'hFFFF_FFFF : 32'h0;
      wr(6'h0C, pol);
      @(negedge clk); pads = pol;
      repeat (4) @(negedge clk);
      wr(6'h14, 32'hFFFF_FFFF);
      for (int i = 0; i < 32; i++) begin
        @(negedge clk); pads[i] = ~pads[i];
        repeat (2) @(negedge clk);
        rd(6'h10, v); check($sformatf("R5 din p%0d pin%0d", p, i), v, pads ^ pol);
        @(negedge clk);
        rd(6'h14, v); check($sformatf("R6 cause p%0d pin%0d", p, i), v, 32'(1) << i);
        check($sformatf("R8 edge irq p%0d pin%0d", p, i), {31'd0, irq}, 1);
        wr(6'h14, 32'(1) << i);
        rd(6'h14, v); check($sformatf("R7 clear p%0d pin%0d", p, i), v, 0);
        check($sformatf("R8 irq gone p%0d pin%0d", p, i), {31'd0, irq}, 0);
        pads[i] = ~pads[i];
        repeat (3) @(negedge clk);
        rd(6'h14, v); check($sformatf("R6 no wrong edge p%0d pin%0d", p, i), v, 0);
      end
    end

    // R7 edge wins over same-cycle clear; zeros leave bits
    wr(6'h0C, 0); @(negedge clk); pads = 0; repeat (4) @(negedge clk);
    wr(6'h14, 32'hFFFF_FFFF);
    pads[1] = 1; repeat (4) @(negedge clk);
    pads[2] = 1; repeat (4) @(negedge clk);
    wr(6'h14, 32'h0000_0002);
    rd(6'h14, v); check("R7 zeros keep bits", v, 32'h4);
    pads[0] = 1;
    @(negedge clk); @(negedge clk);
    req = 1; we = 1; addr = 6'h14; wdata = 32'h0000_0005;
    @(negedge clk); req = 0; we = 0;
    rd(6'h14, v); check("R7 edge wins", v, 32'h1);
    wr(6'h14, 32'hFFFF_FFFF); wr(6'h18, 0);

    // R8 level sweep
    for (int p = 0; p < 2; p++) begin
      pol = p ? 32'hFFFF_FFFF : 32'h0;
      wr(6'h0C, pol);
      for (int i = 0; i < 32; i++) begin
        @(negedge clk); pads = pol; repeat (3) @(negedge clk);
        wr(6'h1C, 32'(1) << i);
        check($sformatf("R8 lvl idle p%0d pin%0d", p, i), {31'd0, irq}, 0);
        pads[i] = ~pads[i]; repeat (2) @(negedge clk);
        check($sformatf("R8 lvl act p%0d pin%0d", p, i), {31'd0, irq}, 1);
        pads[i] = ~pads[i]; repeat (2) @(negedge clk);
        check($sformatf("R8 lvl follows p%0d pin%0d", p, i), {31'd0, irq}, 0);
        pads[i] = ~pads[i]; repeat (2) @(negedge clk);
        wr(6'h1C, 0);
        check($sformatf("R8 lvl masked p%0d pin%0d", p, i), {31'd0, irq}, 0);
      end
    end
    wr(6'h14, 32'hFFFF_FFFF);

    // R9 blink
    wr(6'h00, 32'h0000_0002); wr(6'h20, 32'h3); wr(6'h08, 32'h1);
    t0 = -1; t1 = -1; cyc = 0; v[0] = pad_o[0];
    while (t1 < 0 && cyc < 100) begin
      @(negedge clk); cyc++;
      if (pad_o[0] != v[0]) begin
        v[0] = pad_o[0];
        if (t0 < 0) t0 = cyc; else t1 = cyc;
      end
      check("R2 non-blink pin", {31'd0, pad_o[1]}, 1);
    end
    check("R9 blink interval", 32'(t1 - t0), 32'd4);
    wr(6'h08, 0);
    check("R9 blink off", pad_o, 32'h2);

    finish_run();
  end
endmodule